// File: doc/BRIEF.md
# Time-multiplexed interrupt level synchronizer

The block rebuilds a 32-level interrupt request vector from only 8 shared, active-high, level-sensitive request lines. It drives a 2-bit group select to the peripherals. In each slot, the peripherals assigned to the selected group of 8 levels place their requests on the lines. At the end of the slot the block writes the lines into the matching byte of a pending register.

A 2-bit mode input sets how many groups the select visits. Mode 0 samples only group 0. Modes 1, 2 and 3 rotate through 2, 3 and 4 groups, always starting at group 0. A new mode takes effect only when the rotation returns to group 0. Groups that the current mode does not visit read as zero.

The register is visible in two forms. The read value `pend_o` has bit 7 forced high whenever any of bits 7 to 31 is set, so a reader can tell from that bit alone that levels above 7 may be active. The forwarded vector `irq_o` carries the captured levels unchanged, for a downstream interrupt controller.

Top module: `irq_lvl_sync`

## Requirements
- R1: After reset, `grp_sel_o` is 0, the effective mode is 0, and both `pend_o` and `irq_o` are all zeros.
- R2: With effective mode m, `grp_sel_o` advances once per clock through 0, 1, …, m and then returns to 0. Mode 0 holds it at 0. Mode 1 alternates 0,1. Mode 2 repeats 0,1,2. Mode 3 repeats 0,1,2,3.
- R3: The value on `lvl_i` during a clock in which `grp_sel_o` equals g is written into bits [8g+7:8g] of the register at that clock's rising edge, and it shows on `irq_o` from then on.
- R4: Bytes of visited groups other than the selected one keep their value across the edge.
- R5: A pending bit clears when its group is sampled again with that line low.
- R6: Bytes of groups above the effective mode read as zero on `pend_o` and `irq_o`, and they remain zero if a later mode visits them again before they are resampled.
- R7: `pend_o` bit 7 reads 1 whenever any of bits 7 to 31 of the captured vector is 1. All other bits of `pend_o` equal the captured vector.
- R8: `irq_o` is the captured vector without the bit-7 fold.
- R9: A change on `mode_i` takes effect only at the edge where `grp_sel_o` returns to 0. Until then the old rotation continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral-bus clock, one slot per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Requested number of groups minus one |
| lvl_i | input | 8 | Shared request lines for the selected group |
| grp_sel_o | output | 2 | Group select driven to the peripherals |
| pend_o | output | 32 | Pending register read value, bit 7 folded |
| irq_o | output | 32 | Captured levels forwarded to the interrupt controller |

## Verification
The main function is exercised with one pattern per mode, each chosen to separate a different fault:
- a lone request on level 31, which shows whether the summary fold reaches bit 7;
- a pattern with ones in every byte under mode 0, which shows whether unvisited groups leak through;
- an alternating pattern under mode 1, which shows whether bytes land in the correct group;
- a distinct value per byte under mode 2, which shows whether groups are swapped;
- all ones followed by all zeros under mode 3, which shows whether bits set and clear at the level of the lines.

Directed cases check mode changes in mid-rotation, bytes holding their value while another group is written, clearing when a level drops, and higher groups staying zero after the mode shrinks.

// File: rtl/irq_lvl_sync_pkg.sv
package irq_lvl_sync_pkg;
  localparam int unsigned LINES_DEF  = 8;
  localparam int unsigned GROUPS_DEF = 4;
endpackage

// File: rtl/irq_grp_seq.sv
module irq_grp_seq #(
  parameter int unsigned GROUPS = irq_lvl_sync_pkg::GROUPS_DEF,
  localparam int unsigned SW = $clog2(GROUPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] mode_i,
  output logic [SW-1:0] sel_o,
  output logic [SW-1:0] mode_o
);
  logic [SW-1:0] sel_q, mode_q, sel_d;
  logic          wrap;

  assign wrap  = (sel_q == mode_q);
  assign sel_d = wrap ? '0 : sel_q + SW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      mode_q <= '0;
    end else begin
      sel_q <= sel_d;
      if (wrap) mode_q <= mode_i;  // mode only switches at return to group 0
    end
  end

  assign sel_o  = sel_q;
  assign mode_o = mode_q;

  p_sel_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q <= mode_q);
  p_sel_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sel_q == '0) || (sel_q == $past(sel_q) + SW'(1)));
  p_mode_at_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> (sel_q == '0));
endmodule

// File: rtl/irq_grp_capture.sv
module irq_grp_capture #(
  parameter int unsigned LINES  = irq_lvl_sync_pkg::LINES_DEF,
  parameter int unsigned GROUPS = irq_lvl_sync_pkg::GROUPS_DEF,
  localparam int unsigned SW = $clog2(GROUPS),
  localparam int unsigned NB = LINES * GROUPS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SW-1:0]    sel_i,
  input  logic [SW-1:0]    mode_i,
  input  logic [LINES-1:0] lvl_i,
  output logic [NB-1:0]    store_o
);
  logic [GROUPS-1:0][LINES-1:0] grp_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  grp_q[g] <= '0;
      else if (SW'(g) > mode_i)     grp_q[g] <= '0;  // unvisited groups are flushed
      else if (sel_i == SW'(g))     grp_q[g] <= lvl_i;
    end

    p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == SW'(g)) |=> (grp_q[g] == $past(lvl_i)));
    p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i != SW'(g) && SW'(g) <= mode_i) |=> $stable(grp_q[g]));
    p_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (SW'(g) > mode_i) |=> (grp_q[g] == '0));
  end

  assign store_o = grp_q;
endmodule

// File: rtl/irq_pend_view.sv
module irq_pend_view #(
  parameter int unsigned LINES  = irq_lvl_sync_pkg::LINES_DEF,
  parameter int unsigned GROUPS = irq_lvl_sync_pkg::GROUPS_DEF,
  localparam int unsigned SW = $clog2(GROUPS),
  localparam int unsigned NB = LINES * GROUPS
) (
  input  logic [NB-1:0] store_i,
  input  logic [SW-1:0] mode_i,
  output logic [NB-1:0] irq_o,
  output logic [NB-1:0] pend_o
);
  logic [NB-1:0] vis;

  always_comb begin
    for (int g = 0; g < GROUPS; g++) begin
      vis[g*LINES +: LINES] = (g <= int'(mode_i)) ? store_i[g*LINES +: LINES] : '0;
    end
  end

  assign irq_o = vis;
  // top bit of group 0 doubles as summary of everything at or above it
  assign pend_o = {vis[NB-1:LINES], |vis[NB-1:LINES-1], vis[LINES-2:0]};
endmodule

// File: rtl/irq_lvl_sync.sv
module irq_lvl_sync #(
  parameter int unsigned LINES  = irq_lvl_sync_pkg::LINES_DEF,
  parameter int unsigned GROUPS = irq_lvl_sync_pkg::GROUPS_DEF,
  localparam int unsigned SW = $clog2(GROUPS),
  localparam int unsigned NB = LINES * GROUPS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SW-1:0]    mode_i,
  input  logic [LINES-1:0] lvl_i,
  output logic [SW-1:0]    grp_sel_o,
  output logic [NB-1:0]    pend_o,
  output logic [NB-1:0]    irq_o
);
  logic [SW-1:0] sel, mode_eff;
  logic [NB-1:0] store;

  irq_grp_seq #(.GROUPS(GROUPS)) u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode_i),
    .sel_o (sel),
    .mode_o(mode_eff)
  );

  irq_grp_capture #(.LINES(LINES), .GROUPS(GROUPS)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .mode_i (mode_eff),
    .lvl_i  (lvl_i),
    .store_o(store)
  );

  irq_pend_view #(.LINES(LINES), .GROUPS(GROUPS)) u_view (
    .store_i(store),
    .mode_i (mode_eff),
    .irq_o  (irq_o),
    .pend_o (pend_o)
  );

  assign grp_sel_o = sel;

  p_fold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o[NB-1:LINES-1]) |-> pend_o[LINES-1]);
  p_raw_upper_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o[NB-1:LINES] == irq_o[NB-1:LINES]);
  p_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o == '0) |-> (pend_o == '0));
endmodule

// File: tb/irq_lvl_sync_tb_top.sv
module irq_lvl_sync_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [7:0]  lvl_i = 8'h00;
  logic [1:0]  grp_sel_o;
  logic [31:0] pend_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_lvl_sync dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .lvl_i(lvl_i),
    .grp_sel_o(grp_sel_o), .pend_o(pend_o), .irq_o(irq_o)
  );

  // [33:32] mode, [31:0] levels, byte g = group g
  localparam logic [33:0] VEC [6] = '{
    {2'd3, 32'h8000_0000},
    {2'd0, 32'hFFFF_FF80},
    {2'd1, 32'h0000_A55A},
    {2'd2, 32'h1234_5601},
    {2'd3, 32'hFFFF_FFFF},
    {2'd3, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [31:0] exp_irq(input logic [1:0] m, input logic [31:0] lv);
    logic [31:0] r = '0;
    for (int g = 0; g < 4; g++) if (g <= int'(m)) r[g*8 +: 8] = lv[g*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] fold(input logic [31:0] v);
    logic [31:0] r = v;
    r[7] = |v[31:7];
    return r;
  endfunction

  // apply mode and wait for the rotation to return to group 0 under it
  task automatic sync_mode(input logic [1:0] m, input logic [31:0] lv);
    mode_i = m;
    do begin
      lvl_i = lv[grp_sel_o*8 +: 8];
      step();
    end while (grp_sel_o != 2'd0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk("R1 sel", {30'd0, grp_sel_o}, 32'd0);
    chk("R1 pend", pend_o, 32'd0);
    chk("R1 irq", irq_o, 32'd0);
    rst_ni = 1'b1;
    step();
    chk("R1 sel after release", {30'd0, grp_sel_o}, 32'd0);
    chk("R1 irq after release", irq_o, 32'd0);

    // vector walk: R2 sequence, R3 capture, R5 clear, R6 mask, R7 fold, R8 raw
    for (int i = 0; i < 6; i++) begin
      logic [1:0]  m  = VEC[i][33:32];
      logic [31:0] lv = VEC[i][31:0];
      sync_mode(m, lv);
      for (int s = 0; s < 2 * (int'(m) + 1); s++) begin
        chk("R2 select order", {30'd0, grp_sel_o}, 32'(s % (int'(m) + 1)));
        lvl_i = lv[grp_sel_o*8 +: 8];
        step();
      end
      chk("R3/R6/R8 irq", irq_o, exp_irq(m, lv));
      chk("R7 pend", pend_o, fold(exp_irq(m, lv)));
    end
    lvl_i = 8'h00;

    // R9 deferred mode change
    sync_mode(2'd3, 32'h0);
    step();
    chk("R9 sel1", {30'd0, grp_sel_o}, 32'd1);
    mode_i = 2'd0;
    step(); chk("R9 old rotation sel2", {30'd0, grp_sel_o}, 32'd2);
    step(); chk("R9 old rotation sel3", {30'd0, grp_sel_o}, 32'd3);
    step(); chk("R9 wrap to 0", {30'd0, grp_sel_o}, 32'd0);
    step(); chk("R9 new mode holds 0", {30'd0, grp_sel_o}, 32'd0);

    // R4 hold, R5 clear
    sync_mode(2'd1, 32'h0);
    step(); step();
    chk("R4 start sel0", {30'd0, grp_sel_o}, 32'd0);
    lvl_i = 8'hAA; step();
    lvl_i = 8'h55; step();
    chk("R3 bytes 0 and 1", irq_o, 32'h0000_55AA);
    lvl_i = 8'h0F; step();
    chk("R4 byte1 held", irq_o, 32'h0000_550F);
    chk("R7 fold from byte1", pend_o, 32'h0000_558F);
    lvl_i = 8'h00; step();
    chk("R5 byte1 cleared", irq_o, 32'h0000_000F);
    chk("R5 pend no fold", pend_o, 32'h0000_000F);

    // R6 shrink mode after all ones
    sync_mode(2'd3, 32'hFFFF_FFFF);
    for (int s = 0; s < 4; s++) begin lvl_i = 8'hFF; step(); end
    chk("R6 full", irq_o, 32'hFFFF_FFFF);
    sync_mode(2'd1, 32'hFFFF_FFFF);
    chk("R6 masked at switch", irq_o, 32'h0000_FFFF);
    for (int s = 0; s < 2; s++) begin lvl_i = 8'hFF; step(); end
    chk("R6 upper zero", pend_o, 32'h0000_FFFF);
    sync_mode(2'd3, 32'h0);
    chk("R6 stale not revived", irq_o[31:16], 32'd0);

    done = 1'b1;
    summary();
  end
endmodule